// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Decoder and Bank Tracker

This block sits behind the sampled control pins of a two-bank synchronous graphics DRAM. In every clock cycle it turns the chip-select, row-strobe, column-strobe, write-enable and special-function levels into one-hot command strobes. It uses the bank-select bit and address bit 9 to qualify them, and the present and previous clock-enable levels to tell normal cycles from low-power entry and exit. The strobes are combinational from the pins and the tracked state, so they are valid in the same cycle the pins are presented.

It also keeps a registered idle/active flag for each bank. Each command is checked against the state of the bank it targets. A command that is not allowed in that state raises a one-cycle illegal flag, produces no strobe and leaves the bank state unchanged. A small burst counter follows the last column command. It retires auto-precharge at the end of the burst, tells a clock suspend from a power-down request, and freezes while the internal clock is suspended. The block has no data path and does not enforce timing parameters.

Top module: `sgram_cmd_decoder`

## Requirements
- R1: When `cs_n` is high the cycle is a deselect: no command strobe is asserted and the bank state does not change.
- R2: With `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=1 and the selected bank idle, `cmd_act` pulses and `act_mask_wr` equals `dsf`. That bank reads active from the next cycle on.
- R3: With `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0 and `dsf`=0, `a9`=0 gives `cmd_pre` and idles only the selected bank. `a9`=1 gives `cmd_pre_all` and idles both banks.
- R4: `ras_n`=1 with `cas_n`=0 is a column command: `we_n`=1 with `dsf`=0 is a read, `we_n`=0 with `dsf`=0 a write, and `we_n`=0 with `dsf`=1 a block write. Each one strobes only when the selected bank is active.
- R5: On a column command `auto_pre` follows `a9`. With auto-precharge, the bank returns to idle on the clock edge that completes `BURST_LEN` advancing cycles for a read or write, or one cycle for a block write.
- R6: `ras_n`, `cas_n` and `we_n` all low is a mode-register load (`dsf`=0), legal only with both banks idle, or a special mode-register load (`dsf`=1), legal in any bank state.
- R7: `ras_n`=1, `cas_n`=1, `we_n`=0, `dsf`=0 is a burst stop. It ends the running burst, and it is illegal while an auto-precharge burst is running.
- R8: `ras_n`=0, `cas_n`=0, `we_n`=1, `dsf`=0 with clock enable held high is auto refresh, and with clock enable falling it is self-refresh entry. Both are legal only with both banks idle.
- R9: On a falling clock enable with no burst running, a deselect or no-operation yields `pdn_entry`. During a burst, or with any other command, it yields `clk_susp`. The burst counter holds on every edge where `cke_prev` is low.
- R10: On a rising clock enable, a deselect or no-operation yields `sref_exit` after a self-refresh entry and `pdn_exit` after a power-down entry. An exit from clock suspend strobes nothing.
- R11: The encodings that combine `dsf`=1 with a precharge, read, burst stop or refresh pattern are reserved and raise `illegal_cmd`.
- R12: An illegal command raises `illegal_cmd` for that cycle only, asserts no strobe and leaves the bank state unchanged. A read, write or block write issued while an auto-precharge burst runs is illegal.
- R13: At most one of the command strobes and `illegal_cmd` is high in any cycle. A no-operation asserts none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low to enable decoding |
| ras_n | input | 1 | Row strobe level |
| cas_n | input | 1 | Column strobe level |
| we_n | input | 1 | Write-enable level |
| dsf | input | 1 | Special-function level |
| bank_sel | input | BANK_BITS | Target bank |
| a9 | input | 1 | Precharge-all / auto-precharge qualifier |
| cke | input | 1 | Clock enable in this cycle |
| cke_prev | input | 1 | Clock enable in the previous cycle |
| cmd_act | output | 1 | Bank activate |
| act_mask_wr | output | 1 | Activate selects masked writes |
| cmd_pre | output | 1 | Single-bank precharge |
| cmd_pre_all | output | 1 | Precharge of every bank |
| cmd_rd | output | 1 | Read |
| cmd_wr | output | 1 | Write |
| cmd_bw | output | 1 | Block write |
| auto_pre | output | 1 | Column command carries auto-precharge |
| cmd_mrs | output | 1 | Mode-register load |
| cmd_smrs | output | 1 | Special mode-register load |
| cmd_bst | output | 1 | Burst stop |
| cmd_aref | output | 1 | Auto refresh |
| sref_entry | output | 1 | Self-refresh entry |
| sref_exit | output | 1 | Self-refresh exit |
| pdn_entry | output | 1 | Power-down entry |
| pdn_exit | output | 1 | Power-down exit |
| clk_susp | output | 1 | Clock-suspend entry |
| bank_active | output | 2**BANK_BITS | Per-bank active flag |
| illegal_cmd | output | 1 | Command not allowed in the present state |

## Verification
Auto-precharge retirement and a newly decoded command can land on the same clock edge. On that edge the bank being closed by its own burst may also be the target of the new command. The bench provokes this by issuing an activate to that bank in the final beat of an auto-precharge read. The activate must be judged against the still-active state, so it is flagged illegal, and the bank must read idle in the following cycle. A second overlap, a clock-enable drop in the middle of a burst, is judged by checking that the suspend strobe appears instead of power-down and that the auto-precharge closes the bank two cycles late.

// File: rtl/sgcmd_pkg.sv
package sgcmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_ACT,
    OP_PRE,
    OP_WR,
    OP_BW,
    OP_RD,
    OP_MRS,
    OP_SMRS,
    OP_BST,
    OP_REF,
    OP_BAD
  } op_e;

  typedef enum logic [1:0] {
    LP_NONE,
    LP_PDN,
    LP_SREF,
    LP_SUSP
  } lp_e;

  typedef struct packed {
    logic act;
    logic pre;
    logic pre_all;
    logic rd;
    logic wr;
    logic bw;
    logic mrs;
    logic smrs;
    logic bst;
    logic aref;
    logic sref_in;
    logic sref_out;
    logic pdn_in;
    logic pdn_out;
    logic susp;
  } strb_t;

endpackage

// File: rtl/sgcmd_decode.sv
module sgcmd_decode
  import sgcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic dsf,
  output op_e  op,
  output logic quiet
);

  always_comb begin
    op = OP_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011: op = OP_ACT;
        3'b010: op = dsf ? OP_BAD : OP_PRE;
        3'b100: op = dsf ? OP_BW : OP_WR;
        3'b101: op = dsf ? OP_BAD : OP_RD;
        3'b000: op = dsf ? OP_SMRS : OP_MRS;
        3'b110: op = dsf ? OP_BAD : OP_BST;
        3'b001: op = dsf ? OP_BAD : OP_REF;
        default: op = OP_NOP;
      endcase
    end
  end

  assign quiet = (op == OP_NOP);

endmodule

// File: rtl/sgcmd_ctrl.sv
module sgcmd_ctrl
  import sgcmd_pkg::*;
#(
  parameter int BANK_BITS = 1,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  op_e                  op,
  input  logic                 quiet,
  input  logic                 dsf,
  input  logic                 a9,
  input  logic                 cke,
  input  logic                 cke_prev,
  input  logic [BANK_BITS-1:0] bank_sel,
  input  logic [NUM_BANKS-1:0] bank_active,
  input  logic                 busy,
  input  logic                 ap_pend,
  output strb_t                strb,
  output logic                 act_mask_wr,
  output logic                 auto_pre,
  output logic                 illegal
);

  lp_e  lp_q;
  logic tgt_active;
  logic all_idle;

  assign tgt_active = bank_active[bank_sel];
  assign all_idle   = (bank_active == '0);

  always_comb begin
    strb    = '0;
    illegal = 1'b0;
    unique case ({cke_prev, cke})
      2'b11: begin
        unique case (op)
          OP_ACT:  if (!tgt_active) strb.act = 1'b1; else illegal = 1'b1;
          OP_PRE:  if (a9) strb.pre_all = 1'b1; else strb.pre = 1'b1;
          OP_RD:   if (tgt_active && !ap_pend) strb.rd = 1'b1; else illegal = 1'b1;
          OP_WR:   if (tgt_active && !ap_pend) strb.wr = 1'b1; else illegal = 1'b1;
          OP_BW:   if (tgt_active && !ap_pend) strb.bw = 1'b1; else illegal = 1'b1;
          OP_MRS:  if (all_idle) strb.mrs = 1'b1; else illegal = 1'b1;
          OP_SMRS: strb.smrs = 1'b1;
          OP_BST:  if (!ap_pend) strb.bst = 1'b1; else illegal = 1'b1;
          OP_REF:  if (all_idle) strb.aref = 1'b1; else illegal = 1'b1;
          OP_BAD:  illegal = 1'b1;
          default: ;
        endcase
      end
      2'b10: begin
        if (op == OP_REF) begin
          if (all_idle) strb.sref_in = 1'b1; else illegal = 1'b1;
        end else if (busy || !quiet) begin
          strb.susp = 1'b1;
        end else begin
          strb.pdn_in = 1'b1;
        end
      end
      2'b01: begin
        unique case (lp_q)
          LP_SREF: if (quiet) strb.sref_out = 1'b1; else illegal = 1'b1;
          LP_PDN:  if (quiet) strb.pdn_out = 1'b1; else illegal = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign act_mask_wr = strb.act & dsf;
  assign auto_pre    = a9 & (strb.rd | strb.wr | strb.bw);

  // Remembers which low-power state the clock-enable drop selected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= LP_NONE;
    end else if (cke_prev && !cke) begin
      if (strb.sref_in)     lp_q <= LP_SREF;
      else if (strb.pdn_in) lp_q <= LP_PDN;
      else                  lp_q <= LP_SUSP;
    end else if (!cke_prev && cke) begin
      lp_q <= LP_NONE;
    end
  end

endmodule

// File: rtl/sgcmd_banks.sv
module sgcmd_banks #(
  parameter int BANK_BITS = 1,
  parameter int BURST_LEN = 4,
  localparam int NUM_BANKS = 1 << BANK_BITS,
  localparam int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 do_act,
  input  logic                 do_pre,
  input  logic                 do_pre_all,
  input  logic                 do_col,
  input  logic                 do_bw,
  input  logic                 col_ap,
  input  logic                 do_bst,
  input  logic [BANK_BITS-1:0] bank_sel,
  output logic [NUM_BANKS-1:0] bank_active,
  output logic                 busy,
  output logic                 ap_pend,
  output logic                 ap_due
);

  logic [CNT_W-1:0]     cnt_q;
  logic                 ap_q;
  logic [BANK_BITS-1:0] burst_bank_q;
  logic                 burst_cut;

  assign busy      = (cnt_q != '0);
  assign ap_pend   = busy & ap_q;
  assign ap_due    = ap_pend & adv & (cnt_q == CNT_W'(1));
  assign burst_cut = do_pre_all | (do_pre & (bank_sel == burst_bank_q));

  // Burst beat counter, frozen while the internal clock is suspended
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      ap_q         <= 1'b0;
      burst_bank_q <= '0;
    end else if (do_col || do_bw) begin
      cnt_q        <= do_bw ? CNT_W'(1) : CNT_W'(BURST_LEN);
      ap_q         <= col_ap;
      burst_bank_q <= bank_sel;
    end else if (do_bst || burst_cut) begin
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (adv && busy) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) ap_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == BANK_BITS'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_active[b] <= 1'b0;
      end else if (do_act && hit) begin
        bank_active[b] <= 1'b1;
      end else if (do_pre_all || (do_pre && hit) ||
                   (ap_due && burst_bank_q == BANK_BITS'(b))) begin
        bank_active[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sgram_cmd_decoder.sv
module sgram_cmd_decoder
  import sgcmd_pkg::*;
#(
  parameter int BANK_BITS = 1,
  parameter int BURST_LEN = 4,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 dsf,
  input  logic [BANK_BITS-1:0] bank_sel,
  input  logic                 a9,
  input  logic                 cke,
  input  logic                 cke_prev,
  output logic                 cmd_act,
  output logic                 act_mask_wr,
  output logic                 cmd_pre,
  output logic                 cmd_pre_all,
  output logic                 cmd_rd,
  output logic                 cmd_wr,
  output logic                 cmd_bw,
  output logic                 auto_pre,
  output logic                 cmd_mrs,
  output logic                 cmd_smrs,
  output logic                 cmd_bst,
  output logic                 cmd_aref,
  output logic                 sref_entry,
  output logic                 sref_exit,
  output logic                 pdn_entry,
  output logic                 pdn_exit,
  output logic                 clk_susp,
  output logic [NUM_BANKS-1:0] bank_active,
  output logic                 illegal_cmd
);

  op_e   op;
  logic  quiet;
  strb_t strb;
  logic  busy;
  logic  ap_pend;
  logic  ap_due;

  sgcmd_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .dsf   (dsf),
    .op    (op),
    .quiet (quiet)
  );

  sgcmd_ctrl #(.BANK_BITS(BANK_BITS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .quiet       (quiet),
    .dsf         (dsf),
    .a9          (a9),
    .cke         (cke),
    .cke_prev    (cke_prev),
    .bank_sel    (bank_sel),
    .bank_active (bank_active),
    .busy        (busy),
    .ap_pend     (ap_pend),
    .strb        (strb),
    .act_mask_wr (act_mask_wr),
    .auto_pre    (auto_pre),
    .illegal     (illegal_cmd)
  );

  sgcmd_banks #(.BANK_BITS(BANK_BITS), .BURST_LEN(BURST_LEN)) u_banks (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (cke_prev),
    .do_act      (strb.act),
    .do_pre      (strb.pre),
    .do_pre_all  (strb.pre_all),
    .do_col      (strb.rd | strb.wr),
    .do_bw       (strb.bw),
    .col_ap      (auto_pre),
    .do_bst      (strb.bst),
    .bank_sel    (bank_sel),
    .bank_active (bank_active),
    .busy        (busy),
    .ap_pend     (ap_pend),
    .ap_due      (ap_due)
  );

  assign cmd_act     = strb.act;
  assign cmd_pre     = strb.pre;
  assign cmd_pre_all = strb.pre_all;
  assign cmd_rd      = strb.rd;
  assign cmd_wr      = strb.wr;
  assign cmd_bw      = strb.bw;
  assign cmd_mrs     = strb.mrs;
  assign cmd_smrs    = strb.smrs;
  assign cmd_bst     = strb.bst;
  assign cmd_aref    = strb.aref;
  assign sref_entry  = strb.sref_in;
  assign sref_exit   = strb.sref_out;
  assign pdn_entry   = strb.pdn_in;
  assign pdn_exit    = strb.pdn_out;
  assign clk_susp    = strb.susp;

endmodule

// File: rtl/sgcmd_checker.sv
module sgcmd_checker #(
  parameter int BANK_BITS = 1,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 cke,
  input logic                 cke_prev,
  input logic [BANK_BITS-1:0] bank_sel,
  input logic                 cmd_act,
  input logic                 cmd_pre,
  input logic                 cmd_pre_all,
  input logic                 cmd_rd,
  input logic                 cmd_wr,
  input logic                 cmd_bw,
  input logic                 auto_pre,
  input logic                 cmd_mrs,
  input logic                 cmd_smrs,
  input logic                 cmd_bst,
  input logic                 cmd_aref,
  input logic                 sref_entry,
  input logic                 sref_exit,
  input logic                 pdn_entry,
  input logic                 pdn_exit,
  input logic                 clk_susp,
  input logic [NUM_BANKS-1:0] bank_active,
  input logic                 illegal_cmd,
  input logic                 ap_due
);

  logic any_cmd;
  assign any_cmd = cmd_act | cmd_pre | cmd_pre_all | cmd_rd | cmd_wr | cmd_bw |
                   cmd_mrs | cmd_smrs | cmd_bst | cmd_aref;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke && cke_prev) |-> !any_cmd);

  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke && cke_prev && !ap_due) |=> $stable(bank_active));

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |=> bank_active[$past(bank_sel)]);

  // R3
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_all |=> (bank_active == '0));

  // R4
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr || cmd_bw) |-> bank_active[bank_sel]);

  // R5
  ap_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (cmd_rd || cmd_wr || cmd_bw));

  // R6
  mrs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mrs |-> (bank_active == '0));

  // R8
  refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_aref || sref_entry) |-> (bank_active == '0));

  // R12
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_cmd && !ap_due) |=> $stable(bank_active));

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_pre, cmd_pre_all, cmd_rd, cmd_wr, cmd_bw, cmd_mrs,
              cmd_smrs, cmd_bst, cmd_aref, sref_entry, sref_exit, pdn_entry,
              pdn_exit, clk_susp, illegal_cmd}));

endmodule

bind sgram_cmd_decoder sgcmd_checker #(.BANK_BITS(BANK_BITS)) u_sgcmd_checker (.*);

// File: tb/test_sgram_cmd_decoder.sv
`timescale 1ns/1ps
module test_sgram_cmd_decoder;

  localparam logic [15:0] S_ACT  = 16'h8000;
  localparam logic [15:0] S_PRE  = 16'h4000;
  localparam logic [15:0] S_PALL = 16'h2000;
  localparam logic [15:0] S_RD   = 16'h1000;
  localparam logic [15:0] S_WR   = 16'h0800;
  localparam logic [15:0] S_BW   = 16'h0400;
  localparam logic [15:0] S_MRS  = 16'h0200;
  localparam logic [15:0] S_SMRS = 16'h0100;
  localparam logic [15:0] S_BST  = 16'h0080;
  localparam logic [15:0] S_REF  = 16'h0040;
  localparam logic [15:0] S_SIN  = 16'h0020;
  localparam logic [15:0] S_SOUT = 16'h0010;
  localparam logic [15:0] S_PIN  = 16'h0008;
  localparam logic [15:0] S_POUT = 16'h0004;
  localparam logic [15:0] S_SUSP = 16'h0002;
  localparam logic [15:0] S_ILL  = 16'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
  logic [0:0] bank_sel = 1'b0;
  logic a9 = 1'b0;
  logic cke = 1'b1;
  logic cke_q = 1'b1;
  logic cmd_act, act_mask_wr, cmd_pre, cmd_pre_all, cmd_rd, cmd_wr, cmd_bw;
  logic auto_pre, cmd_mrs, cmd_smrs, cmd_bst, cmd_aref;
  logic sref_entry, sref_exit, pdn_entry, pdn_exit, clk_susp, illegal_cmd;
  logic [1:0] bank_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cke_q <= cke;

  sgram_cmd_decoder i_sgram_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .bank_sel(bank_sel), .a9(a9), .cke(cke),
    .cke_prev(cke_q), .cmd_act(cmd_act), .act_mask_wr(act_mask_wr),
    .cmd_pre(cmd_pre), .cmd_pre_all(cmd_pre_all), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .cmd_bw(cmd_bw), .auto_pre(auto_pre), .cmd_mrs(cmd_mrs),
    .cmd_smrs(cmd_smrs), .cmd_bst(cmd_bst), .cmd_aref(cmd_aref),
    .sref_entry(sref_entry), .sref_exit(sref_exit), .pdn_entry(pdn_entry),
    .pdn_exit(pdn_exit), .clk_susp(clk_susp), .bank_active(bank_active),
    .illegal_cmd(illegal_cmd)
  );

  function automatic logic [15:0] strobes();
    return {cmd_act, cmd_pre, cmd_pre_all, cmd_rd, cmd_wr, cmd_bw, cmd_mrs,
            cmd_smrs, cmd_bst, cmd_aref, sref_entry, sref_exit, pdn_entry,
            pdn_exit, clk_susp, illegal_cmd};
  endfunction

  task automatic chk_s(input logic [15:0] exp, input string tag);
    checks++;
    if (strobes() !== exp) begin
      fails++;
      $display("FAIL %s strobes actual=%h expected=%h", tag, strobes(), exp);
    end
  endtask

  task automatic chk_b(input logic [1:0] exp, input string tag);
    checks++;
    if (bank_active !== exp) begin
      fails++;
      $display("FAIL %s bank_active actual=%b expected=%b", tag, bank_active, exp);
    end
  endtask

  task automatic chk_1(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, r, a, w, d, b, x, k);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; dsf = d;
    bank_sel = b; a9 = x; cke = k;
    #1;
  endtask

  task automatic nop();                  step(0, 1, 1, 1, 0, 0, 0, 1); endtask
  task automatic desel(input logic k);   step(1, 0, 1, 1, 0, 0, 0, k); endtask
  task automatic act(input logic b, d);  step(0, 0, 1, 1, d, b, 0, 1); endtask
  task automatic pre(input logic b, al); step(0, 0, 1, 0, 0, b, al, 1); endtask
  task automatic rd(input logic b, ap);  step(0, 1, 0, 1, 0, b, ap, 1); endtask
  task automatic wr(input logic b, ap);  step(0, 1, 0, 0, 0, b, ap, 1); endtask
  task automatic bw(input logic b, ap);  step(0, 1, 0, 0, 1, b, ap, 1); endtask
  task automatic mrs(input logic d);     step(0, 0, 0, 0, d, 0, 0, 1); endtask
  task automatic bst();                  step(0, 1, 1, 0, 0, 0, 0, 1); endtask
  task automatic refr(input logic k);    step(0, 0, 0, 1, 0, 0, 0, k); endtask

  task automatic t_reset();
    nop();
    chk_s(16'h0, "R13 nop after reset");
    chk_b(2'b00, "R13 banks idle after reset");
  endtask

  task automatic t_deselect();
    desel(1);
    chk_s(16'h0, "R1 deselect masks activate pattern");
    nop();
    chk_b(2'b00, "R1 deselect leaves banks idle");
  endtask

  task automatic t_activate();
    act(1, 1);
    chk_s(S_ACT, "R2 activate bank1");
    chk_1(act_mask_wr, 1'b1, "R2 masked write flag follows dsf high");
    act(0, 0);
    chk_b(2'b10, "R2 bank1 active");
    chk_1(act_mask_wr, 1'b0, "R2 masked write flag follows dsf low");
    act(0, 0);
    chk_b(2'b11, "R2 both active");
    chk_s(S_ILL, "R12 activate of active bank");
    nop();
    chk_b(2'b11, "R12 illegal activate leaves state");
  endtask

  task automatic t_column();
    rd(1, 0);
    chk_s(S_RD, "R4 read bank1");
    chk_1(auto_pre, 1'b0, "R5 read without auto-precharge");
    wr(0, 0);
    chk_s(S_WR, "R4 write bank0");
    bw(1, 0);
    chk_s(S_BW, "R4 block write bank1");
    pre(1, 0);
    chk_s(S_PRE, "R3 precharge bank1");
    nop();
    chk_b(2'b01, "R3 only bank1 idled");
    rd(1, 0);
    chk_s(S_ILL, "R4 read of idle bank");
    pre(0, 1);
    chk_s(S_PALL, "R3 precharge all");
    nop();
    chk_b(2'b00, "R3 all banks idle");
  endtask

  task automatic t_mode();
    mrs(0);
    chk_s(S_MRS, "R6 mode load when idle");
    act(0, 0);
    mrs(0);
    chk_s(S_ILL, "R6 mode load with active bank");
    mrs(1);
    chk_s(S_SMRS, "R6 special load with active bank");
    pre(0, 1);
    nop();
    chk_b(2'b00, "R6 banks idle after precharge all");
  endtask

  task automatic t_autopre();
    act(0, 0);
    nop();
    rd(0, 1);
    chk_s(S_RD, "R5 read with auto-precharge");
    chk_1(auto_pre, 1'b1, "R5 auto-precharge flag");
    nop();
    chk_b(2'b01, "R5 active beat 1");
    rd(0, 0);
    chk_s(S_ILL, "R12 read during auto-precharge burst");
    chk_b(2'b01, "R5 active beat 2");
    nop();
    chk_b(2'b01, "R5 active beat 3");
    act(0, 0);
    chk_s(S_ILL, "R12 activate on final beat");
    chk_b(2'b01, "R5 active beat 4");
    nop();
    chk_b(2'b00, "R5 bank idle after burst");
  endtask

  task automatic t_bstop();
    act(0, 0);
    rd(0, 0);
    bst();
    chk_s(S_BST, "R7 burst stop");
    desel(0);
    chk_s(S_PIN, "R9 power-down after stopped burst");
    desel(0);
    chk_s(16'h0, "R9 held low");
    desel(1);
    chk_s(S_POUT, "R10 power-down exit");
    rd(0, 1);
    bst();
    chk_s(S_ILL, "R7 burst stop during auto-precharge");
    nop();
    nop();
    nop();
    nop();
    chk_b(2'b00, "R7 auto-precharge burst ran to completion");
  endtask

  task automatic t_suspend();
    act(0, 0);
    rd(0, 1);
    nop();
    desel(0);
    chk_s(S_SUSP, "R9 suspend instead of power-down in burst");
    desel(0);
    chk_s(16'h0, "R9 suspended");
    nop();
    chk_s(16'h0, "R10 suspend exit strobes nothing");
    nop();
    chk_b(2'b01, "R9 counter frozen beat a");
    nop();
    chk_b(2'b01, "R9 counter frozen beat b");
    nop();
    chk_b(2'b00, "R9 bank idle two cycles late");
  endtask

  task automatic t_refresh();
    refr(1);
    chk_s(S_REF, "R8 auto refresh");
    act(1, 0);
    refr(1);
    chk_s(S_ILL, "R8 refresh with active bank");
    pre(1, 1);
    refr(0);
    chk_s(S_SIN, "R8 self-refresh entry");
    desel(0);
    chk_s(16'h0, "R8 self-refresh held");
    nop();
    chk_s(S_SOUT, "R10 self-refresh exit");
    nop();
    chk_b(2'b00, "R8 banks idle after self-refresh");
  endtask

  task automatic t_reserved();
    step(0, 0, 1, 0, 1, 0, 0, 1);
    chk_s(S_ILL, "R11 precharge with dsf");
    step(0, 1, 0, 1, 1, 0, 0, 1);
    chk_s(S_ILL, "R11 read with dsf");
    step(0, 1, 1, 0, 1, 0, 0, 1);
    chk_s(S_ILL, "R11 burst stop with dsf");
    step(0, 0, 0, 1, 1, 0, 0, 1);
    chk_s(S_ILL, "R11 refresh with dsf");
    nop();
    chk_s(16'h0, "R12 illegal flag lasts one cycle");
    chk_b(2'b00, "R11 banks untouched");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_deselect();
    t_activate();
    t_column();
    t_mode();
    t_autopre();
    t_bstop();
    t_suspend();
    t_refresh();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule